// File: doc/BRIEF.md
# Lockable I2C Trim Wiper Register

This block is the digital half of a 64-tap trim potentiometer. It holds a 6-bit wiper code that the analog tap selector reads. An I2C host sets that code over a two-wire bus. Until the host asks for a permanent setting, the code may be changed any number of times, and each change reaches the wiper output at once. A single command byte carries both a new code and an optional lock flag. When the flag is set, the code is stored first. A fuse-burn sequence then starts, and it is modelled by a counter of programmable length. When the counter expires, the code is frozen for good.

The host reads one byte back. That byte carries the wiper code and a two-bit lock status, so the host can tell an open part from a successfully locked part and from a part whose burn failed. A test input stands in for a fuse that did not blow. One input pin sets the low bit of the 7-bit slave address, so two parts can share a bus. The bus pins are modelled as open-drain: the block samples SCL and SDA through synchronisers and only ever pulls SDA low.

Top module: `otp_trim_wiper`

## Requirements
- R1: After reset the wiper output is 0, the lock status is 00, the program-busy output is low and SDA is released.
- R2: The slave address is {DEV_ADDR_HI[5:0], addr_sel_i}. A frame to any other address gets no acknowledge (SDA stays released in the ninth bit) and changes nothing.
- R3: Before a lock, each acknowledged write frame whose command byte has bit 7 clear loads command bits 5:0 into the wiper output before the stop condition. Writes may repeat without limit.
- R4: A read frame returns one byte, MSB first: bits 7:6 are the lock status and bits 5:0 the wiper code.
- R5: A command byte with bit 7 set stores bits 5:0 first and then holds program-busy high for exactly PROG_CYCLES clock cycles. The lock status stays 00 while program-busy is high.
- R6: While program-busy is high, a write-direction address byte is not acknowledged. A read-direction address byte is acknowledged and returns the current state.
- R7: If fuse_fail_i is low in the last program cycle, the lock status becomes 11.
- R8: If fuse_fail_i is high in the last program cycle, the lock status becomes 10. The code 01 never occurs.
- R9: Once the lock status is non-zero it never changes again. Write frames are still acknowledged, but their code and lock flag are discarded: the wiper stays fixed and program-busy does not rise again.
- R10: Command bit 6 is ignored.
- R11: The wiper output changes only in the cycle after an accepted command byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Sampled serial clock line |
| sda_i | input | 1 | Sampled serial data line |
| sda_o | output | 1 | Data value driven while enabled (always 0) |
| sda_oe | output | 1 | High pulls SDA low |
| addr_sel_i | input | 1 | Low bit of the slave address |
| fuse_fail_i | input | 1 | Test input: fuse burn fails when high at the end of programming |
| wiper_o | output | 6 | Wiper tap code |
| prog_busy_o | output | 1 | High while the fuse-program counter runs |

## Verification
The checker watches the lock-state relations on every cycle. It confirms that the status never takes the value 01 and that a non-zero status is permanent. It also confirms that the status stays 00 during programming, that the wiper is frozen once locked, and that the wiper moves only after a command strobe. The bench scenarios show the properties that depend on bus framing: address matching on every one of the 128 addresses, the write-during-burn refusal, the read byte layout for every code, and the exact burn length. They also cover both burn outcomes, including that post-lock writes are acknowledged but have no effect at the wiper pins.

// File: rtl/otp_trim_pkg.sv
// Shared types and constants for the lockable trim wiper.
// Assumes one command byte per write frame and one status byte per read frame.
package otp_trim_pkg;
    localparam int WIPER_W  = 6;
    localparam int BYTE_W   = 8;
    localparam int LOCK_BIT = 7;

    typedef enum logic [2:0] {
        BS_IDLE, BS_ADDR, BS_AACK, BS_WR, BS_WACK, BS_RD, BS_RACK, BS_WAIT
    } bus_state_t;

    typedef enum logic [1:0] {
        LK_OPEN = 2'b00,
        LK_FAIL = 2'b10,
        LK_GOOD = 2'b11
    } lock_state_t;
endpackage

// File: rtl/i2c_line_sync.sv
// Brings SCL and SDA into the clock domain and flags bus events.
// Assumes the system clock is far faster than SCL. Both lines reset to the idle (high) level.
module i2c_line_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic [SYNC_STAGES-1:0] scl_sh;
    logic [SYNC_STAGES-1:0] sda_sh;
    logic scl_s, scl_d, sda_d;

    // Synchroniser chains plus one delayed copy for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_sh <= '1;
            sda_sh <= '1;
            scl_d  <= 1'b1;
            sda_d  <= 1'b1;
        end else begin
            scl_sh <= {scl_sh[SYNC_STAGES-2:0], scl_i};
            sda_sh <= {sda_sh[SYNC_STAGES-2:0], sda_i};
            scl_d  <= scl_s;
            sda_d  <= sda_s;
        end
    end

    // Event decode from the synchronised and delayed line levels.
    always_comb begin
        scl_s     = scl_sh[SYNC_STAGES-1];
        sda_s     = sda_sh[SYNC_STAGES-1];
        scl_rise  = scl_s & ~scl_d;
        scl_fall  = ~scl_s & scl_d;
        start_det = scl_s & scl_d & sda_d & ~sda_s;
        stop_det  = scl_s & scl_d & ~sda_d & sda_s;
    end
endmodule

// File: rtl/i2c_byte_slave.sv
// Frame engine: matches the address, receives one command byte or sends one status byte.
// Assumes bus events arrive from i2c_line_sync. SDA is only pulled low, never driven high.
module i2c_byte_slave
    import otp_trim_pkg::*;
#(
    parameter int ADDR_W = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sda_s,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              start_det,
    input  logic              stop_det,
    input  logic [ADDR_W-1:0] dev_addr,
    input  logic              wr_block,
    input  logic [BYTE_W-1:0] rd_byte,
    output logic              sda_oe,
    output logic              wr_stb,
    output logic [BYTE_W-1:0] wr_byte
);
    localparam int CNT_W = $clog2(BYTE_W + 1);

    bus_state_t        state;
    logic [CNT_W-1:0]  bit_cnt;
    logic [BYTE_W-1:0] shreg;
    logic [BYTE_W-1:0] txsh;
    logic              is_read;

    // Frame state machine: bits are shifted in on SCL rise, and SDA changes on SCL fall.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= BS_IDLE;
            bit_cnt <= '0;
            shreg   <= '0;
            txsh    <= '0;
            is_read <= 1'b0;
            sda_oe  <= 1'b0;
            wr_stb  <= 1'b0;
            wr_byte <= '0;
        end else begin
            wr_stb <= 1'b0;
            if (start_det) begin
                state   <= BS_ADDR;
                bit_cnt <= '0;
                sda_oe  <= 1'b0;
            end else if (stop_det) begin
                state  <= BS_IDLE;
                sda_oe <= 1'b0;
            end else if (scl_rise) begin
                if (state == BS_ADDR || state == BS_WR) begin
                    shreg   <= {shreg[BYTE_W-2:0], sda_s};
                    bit_cnt <= bit_cnt + 1'b1;
                end else if (state == BS_RACK) begin
                    state <= BS_WAIT;
                end
            end else if (scl_fall) begin
                case (state)
                    BS_ADDR: if (bit_cnt == CNT_W'(BYTE_W)) begin
                        if (shreg[BYTE_W-1:1] == dev_addr && !(!shreg[0] && wr_block)) begin
                            sda_oe  <= 1'b1;
                            is_read <= shreg[0];
                            state   <= BS_AACK;
                        end else begin
                            state <= BS_WAIT;
                        end
                    end
                    BS_AACK: begin
                        if (is_read) begin
                            txsh    <= rd_byte;
                            sda_oe  <= ~rd_byte[BYTE_W-1];
                            bit_cnt <= CNT_W'(1);
                            state   <= BS_RD;
                        end else begin
                            sda_oe  <= 1'b0;
                            bit_cnt <= '0;
                            state   <= BS_WR;
                        end
                    end
                    BS_WR: if (bit_cnt == CNT_W'(BYTE_W)) begin
                        sda_oe  <= 1'b1;
                        wr_stb  <= 1'b1;
                        wr_byte <= shreg;
                        state   <= BS_WACK;
                    end
                    BS_WACK: begin
                        sda_oe <= 1'b0;
                        state  <= BS_WAIT;
                    end
                    BS_RD: begin
                        if (bit_cnt == CNT_W'(BYTE_W)) begin
                            sda_oe <= 1'b0;
                            state  <= BS_RACK;
                        end else begin
                            sda_oe  <= ~txsh[BYTE_W-2];
                            txsh    <= {txsh[BYTE_W-2:0], 1'b0};
                            bit_cnt <= bit_cnt + 1'b1;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end
endmodule

// File: rtl/otp_wiper_store.sv
// Wiper register with a one-time lock and a timed fuse-burn model.
// Assumes commands arrive as single-cycle strobes. fuse_fail_i is sampled in the final program cycle.
module otp_wiper_store
    import otp_trim_pkg::*;
#(
    parameter int PROG_CYCLES = 50_000_000
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cmd_stb,
    input  logic [BYTE_W-1:0]  cmd_byte,
    input  logic               fuse_fail_i,
    output logic [WIPER_W-1:0] wiper_o,
    output lock_state_t        lock_o,
    output logic               busy_o
);
    localparam int CNT_W = (PROG_CYCLES > 1) ? $clog2(PROG_CYCLES) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(PROG_CYCLES - 1);

    logic [CNT_W-1:0] cnt;

    // Accepts commands while open, runs the burn counter, and records the outcome once.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wiper_o <= '0;
            lock_o  <= LK_OPEN;
            busy_o  <= 1'b0;
            cnt     <= '0;
        end else if (busy_o) begin
            if (cnt == LAST) begin
                busy_o <= 1'b0;
                lock_o <= fuse_fail_i ? LK_FAIL : LK_GOOD;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end else if (cmd_stb && lock_o == LK_OPEN) begin
            wiper_o <= cmd_byte[WIPER_W-1:0];
            if (cmd_byte[LOCK_BIT]) begin
                busy_o <= 1'b1;
                cnt    <= '0;
            end
        end
    end
endmodule

// File: rtl/otp_trim_wiper.sv
// Top level: I2C slave front end joined to the lockable wiper store.
// Assumes an external open-drain pad: sda_oe high pulls the line low.
module otp_trim_wiper
    import otp_trim_pkg::*;
#(
    parameter logic [5:0] DEV_ADDR_HI  = 6'b010110,
    parameter int         PROG_CYCLES  = 50_000_000,
    parameter int         SYNC_STAGES  = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               scl_i,
    input  logic               sda_i,
    output logic               sda_o,
    output logic               sda_oe,
    input  logic               addr_sel_i,
    input  logic               fuse_fail_i,
    output logic [WIPER_W-1:0] wiper_o,
    output logic               prog_busy_o
);
    logic              sda_s, scl_rise, scl_fall, start_det, stop_det;
    logic              cmd_stb;
    logic [BYTE_W-1:0] cmd_byte;
    lock_state_t       lock_status;
    logic [6:0]        dev_addr;
    logic [BYTE_W-1:0] rd_byte;

    // Address and read-byte assembly.
    always_comb begin
        dev_addr = {DEV_ADDR_HI, addr_sel_i};
        rd_byte  = {lock_status, wiper_o};
        sda_o    = 1'b0;
    end

    i2c_line_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det)
    );

    i2c_byte_slave #(.ADDR_W(7)) u_slave (
        .clk(clk), .rst_n(rst_n), .sda_s(sda_s), .scl_rise(scl_rise),
        .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det),
        .dev_addr(dev_addr), .wr_block(prog_busy_o), .rd_byte(rd_byte),
        .sda_oe(sda_oe), .wr_stb(cmd_stb), .wr_byte(cmd_byte)
    );

    otp_wiper_store #(.PROG_CYCLES(PROG_CYCLES)) u_store (
        .clk(clk), .rst_n(rst_n), .cmd_stb(cmd_stb), .cmd_byte(cmd_byte),
        .fuse_fail_i(fuse_fail_i), .wiper_o(wiper_o), .lock_o(lock_status),
        .busy_o(prog_busy_o)
    );
endmodule

// File: rtl/otp_trim_wiper_chk.sv
// Cycle-level checks on the lock state and the wiper, bound into the top level.
module otp_trim_wiper_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [5:0] wiper,
    input logic [1:0] status,
    input logic       busy,
    input logic       cmd_stb
);
    p_status_legal_r8: assert property (@(posedge clk) disable iff (!rst_n)
        status != 2'b01);

    p_open_while_prog_r5: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> status == 2'b00);

    p_prog_sets_status_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> status != 2'b00);

    p_status_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (status != 2'b00) |=> $stable(status));

    p_wiper_frozen_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (status != 2'b00) |=> $stable(wiper) && !busy);

    p_wiper_needs_cmd_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(wiper) |-> $past(cmd_stb));
endmodule

bind otp_trim_wiper otp_trim_wiper_chk u_chk (
    .clk(clk), .rst_n(rst_n), .wiper(wiper_o), .status(lock_status),
    .busy(prog_busy_o), .cmd_stb(cmd_stb)
);

// File: tb/tb_otp_trim_wiper.sv
module tb_otp_trim_wiper;
    localparam int         PROG = 2000;
    localparam logic [5:0] HI   = 6'b010110;
    localparam int         Q    = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic addr_sel = 1'b0;
    logic fuse_fail = 1'b0;
    logic sda_o, sda_oe, busy;
    logic [5:0] wiper;
    logic sda_line;
    int checks = 0;
    int fails = 0;
    int busy_cycles = 0;
    bit done = 0;

    always #4 clk = ~clk;
    assign sda_line = sda_m & ~sda_oe;

    otp_trim_wiper #(.DEV_ADDR_HI(HI), .PROG_CYCLES(PROG)) dut (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
        .sda_o(sda_o), .sda_oe(sda_oe), .addr_sel_i(addr_sel),
        .fuse_fail_i(fuse_fail), .wiper_o(wiper), .prog_busy_o(busy)
    );

    always @(negedge clk) if (busy) busy_cycles++;

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wq(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bstart();
        sda_m = 1'b1; scl_m = 1'b1; wq(Q);
        sda_m = 1'b0; wq(Q);
        scl_m = 1'b0; wq(Q);
    endtask

    task automatic bstop();
        sda_m = 1'b0; wq(Q);
        scl_m = 1'b1; wq(Q);
        sda_m = 1'b1; wq(Q);
    endtask

    task automatic bbit(input logic b, output logic r);
        sda_m = b; wq(Q);
        scl_m = 1'b1; wq(Q);
        r = sda_line; wq(Q);
        scl_m = 1'b0; wq(Q);
    endtask

    task automatic send_byte(input logic [7:0] d, output logic ack);
        logic r;
        for (int i = 7; i >= 0; i--) bbit(d[i], r);
        bbit(1'b1, r);
        ack = ~r;
    endtask

    task automatic wr_frame(input logic [6:0] a, input bit with_data,
                            input logic [7:0] d, output logic ack_a, output logic ack_d);
        bstart();
        send_byte({a, 1'b0}, ack_a);
        ack_d = 1'b0;
        if (ack_a && with_data) send_byte(d, ack_d);
        bstop();
    endtask

    task automatic rd_frame(input logic [6:0] a, output logic ack, output logic [7:0] d);
        logic r;
        bstart();
        send_byte({a, 1'b1}, ack);
        d = '0;
        if (ack) begin
            for (int i = 7; i >= 0; i--) begin
                bbit(1'b1, r);
                d[i] = r;
            end
            bbit(1'b1, r);
        end
        bstop();
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog expired");
            finish_run();
        end
    end

    initial begin
        logic aa, ad, ra;
        logic [7:0] rb;
        logic [6:0] me0, me1;
        me0 = {HI, 1'b0};
        me1 = {HI, 1'b1};
        wq(5);
        // R1: reset state
        chk("R1 wiper", wiper, 0);
        chk("R1 busy", busy, 0);
        chk("R1 sda_oe", sda_oe, 0);
        rst_n = 1'b1;
        wq(3);
        rd_frame(me0, ra, rb);
        chk("R1 read ack", ra, 1);
        chk("R1 read byte", rb, 8'h00);

        // R2: full address sweep with addr_sel low
        for (int a = 0; a < 128; a++) begin
            wr_frame(7'(a), 1'b0, 8'h00, aa, ad);
            chk("R2 addr ack", aa, (7'(a) == me0) ? 1 : 0);
        end
        chk("R2 no effect", wiper, 0);

        // R2: addr_sel moves the address
        addr_sel = 1'b1;
        wq(2);
        wr_frame(me0, 1'b1, 8'h05, aa, ad);
        chk("R2 old addr nack", aa, 0);
        chk("R2 unchanged", wiper, 0);
        wr_frame(me1, 1'b1, 8'h05, aa, ad);
        chk("R2 new addr ack", aa, 1);
        chk("R3 wiper after write", wiper, 5);

        // R3 R4 R10: every code, bit 6 set on odd codes
        for (int c = 0; c < 64; c++) begin
            logic [7:0] cmd;
            cmd = 8'(c) | ((c % 2 == 1) ? 8'h40 : 8'h00);
            wr_frame(me1, 1'b1, cmd, aa, ad);
            chk("R3 data ack", ad, 1);
            chk("R3 R10 wiper", wiper, c);
            rd_frame(me1, ra, rb);
            chk("R4 read byte", rb, c);
        end

        // R5 R6 R8: lock with a failing fuse
        fuse_fail = 1'b1;
        busy_cycles = 0;
        wr_frame(me1, 1'b1, 8'hAA, aa, ad);
        chk("R5 lock ack", ad, 1);
        chk("R5 busy", busy, 1);
        chk("R5 code stored", wiper, 6'h2A);
        wr_frame(me1, 1'b1, 8'h01, aa, ad);
        chk("R6 write nack while busy", aa, 0);
        rd_frame(me1, ra, rb);
        chk("R6 read ack while busy", ra, 1);
        chk("R6 R5 read while busy", rb, 8'h2A);
        while (busy) @(negedge clk);
        chk("R5 busy length", busy_cycles, PROG);
        rd_frame(me1, ra, rb);
        chk("R8 failed status", rb, 8'hAA);
        wr_frame(me1, 1'b1, 8'h15, aa, ad);
        chk("R9 ack after lock", ad, 1);
        chk("R9 wiper frozen", wiper, 6'h2A);
        wr_frame(me1, 1'b1, 8'h81, aa, ad);
        wq(2);
        chk("R9 no relock", busy, 0);
        rd_frame(me1, ra, rb);
        chk("R9 status kept", rb, 8'hAA);

        // R7: fresh part, successful burn
        rst_n = 1'b0;
        fuse_fail = 1'b0;
        wq(3);
        rst_n = 1'b1;
        wq(3);
        chk("R1 after reset", wiper, 0);
        busy_cycles = 0;
        wr_frame(me1, 1'b1, 8'h91, aa, ad);
        chk("R5 lock ack", ad, 1);
        while (busy) @(negedge clk);
        chk("R5 busy length", busy_cycles, PROG);
        rd_frame(me1, ra, rb);
        chk("R7 good status", rb, 8'hD1);
        wr_frame(me1, 1'b1, 8'h22, aa, ad);
        chk("R9 wiper frozen", wiper, 6'h11);
        rd_frame(me1, ra, rb);
        chk("R9 R7 status kept", rb, 8'hD1);

        done = 1;
        finish_run();
    end
endmodule